// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column addresses of one burst inside an open SDRAM row. A controller fires a start strobe together with the first column, a burst-length code and an ordering bit. From the next clock on, the block presents one column address per clock. It flags the final beat of a fixed-length burst and holds a busy flag for as long as addresses are being produced.

Fixed bursts of 1, 2, 4 and 8 beats stay inside an aligned block of columns. They follow either wrap-around counting or XOR (interleaved) ordering. A full-page burst steps through the whole row, wrapping past the top column, until the stop input ends it. A new start may arrive on any clock, including the last beat of the running burst, so bursts can follow one another with no idle clock between them.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `col_busy` and `col_last` are 0.
- R2: When `burst_go` is sampled high, the next clock shows `col_busy`=1 and `col_out` equal to the sampled `go_col` (beat 0).
- R3: `go_len` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4, 5 and 6 behave as 1 beat.
- R4: With `go_ilv`=0 and a fixed length BL, beat i holds the start column with its low log2(BL) bits replaced by (start + i) mod BL. The upper bits do not change, and a new address appears on every clock.
- R5: With `go_ilv`=1 and a fixed length BL, beat i holds the start column with its low log2(BL) bits XORed with i.
- R6: A full-page burst outputs (start + i) mod 2^COL_W on beat i, ignores `go_ilv`, never raises `col_last` and stays busy until stopped.
- R7: `col_last` is 1 only on beat BL-1 of a fixed burst, which is beat 0 when BL=1. `col_busy` falls on the clock after that beat unless a new start was sampled.
- R8: A `burst_stop` sampled high without `burst_go` makes `col_busy` 0 on the next clock, and no further addresses follow. While idle it has no effect.
- R9: A `burst_go` sampled while busy, including on the last beat or together with `burst_stop`, begins the new burst on the next clock with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| burst_go | input | 1 | Start strobe for a new burst |
| go_col | input | COL_W | First column of the burst |
| go_len | input | 3 | Burst length code |
| go_ilv | input | 1 | 1 = interleaved ordering, 0 = sequential |
| burst_stop | input | 1 | Terminate the running burst |
| col_out | output | COL_W | Column address of the current beat |
| col_busy | output | 1 | A beat is being presented on `col_out` |
| col_last | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The hardest situations to reach from the ports are a full-page burst that wraps past the top column, and a start that lands exactly on the final beat of the previous burst. Random stimulus seldom holds a full-page burst for hundreds of clocks, and it seldom times a start to the last beat. Directed sequences therefore open a full-page burst near the top of the row and keep it running across the wrap. Other directed sequences issue a new start on the last beat, and a start together with a stop. A seeded random phase mixes all the codes, both orderings and stray stops, and a bench model checks it clock by clock.

// File: rtl/burst_col_gen_pkg.sv
package burst_col_gen_pkg;
  // burst length codes seen on go_len
  typedef enum logic [2:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_PAGE = 3'd7
  } len_code_t;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import burst_col_gen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       len_code,
  output logic [COL_W-1:0] low_mask,
  output logic             page_mode
);
  // low_mask marks the column bits that move during the burst; its value
  // also equals the index of the final beat of a fixed burst
  always_comb begin
    low_mask  = '0;
    page_mode = 1'b0;
    case (len_code)
      LEN_2:    low_mask = COL_W'(1);
      LEN_4:    low_mask = COL_W'(3);
      LEN_8:    low_mask = COL_W'(7);
      LEN_PAGE: begin
        low_mask  = '1;
        page_mode = 1'b1;
      end
      default:  low_mask = '0;  // one beat, also for unused codes
    endcase
  end
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] low_mask,
  input  logic [COL_W-1:0] beat_idx,
  input  logic             xor_order,
  output logic [COL_W-1:0] beat_col
);
  logic [COL_W-1:0] wrap_sum;
  logic [COL_W-1:0] xor_mix;

  assign wrap_sum = base_col + beat_idx;
  assign xor_mix  = base_col ^ beat_idx;

  // each bit either moves with the beat index or keeps the start value
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!low_mask[b])
        beat_col[b] = base_col[b];
      else if (xor_order)
        beat_col[b] = xor_mix[b];
      else
        beat_col[b] = wrap_sum[b];
    end
  end
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [COL_W-1:0] go_col,
  input  logic             go_ilv,
  input  logic [COL_W-1:0] go_mask,
  input  logic             go_page,
  input  logic             stop,
  input  logic [COL_W-1:0] nxt_col,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] mask_q,
  output logic [COL_W-1:0] beat_inc,
  output logic             ilv_q,
  output logic [COL_W-1:0] col_q,
  output logic             busy_q,
  output logic             last_q
);
  logic [COL_W-1:0] beat_q;
  logic             page_q;

  assign beat_inc = beat_q + COL_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      beat_q <= '0;
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      page_q <= 1'b0;
      col_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      beat_q <= '0;
      base_q <= go_col;
      mask_q <= go_mask;
      ilv_q  <= go_ilv & ~go_page;
      page_q <= go_page;
      col_q  <= go_col;
      last_q <= ~go_page & (go_mask == '0);
    end else if (stop || (busy_q && last_q)) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end else if (busy_q) begin
      beat_q <= beat_inc;
      col_q  <= nxt_col;
      last_q <= ~page_q & (beat_inc == mask_q);
    end
  end

  a_r7_last_needs_busy: assert property (@(posedge clk) disable iff (rst)
    last_q |-> busy_q);
  a_r2_first_beat: assert property (@(posedge clk) disable iff (rst)
    go |=> (busy_q && col_q == $past(go_col)));
  a_r8_stop_ends: assert property (@(posedge clk) disable iff (rst)
    (stop && !go) |=> !busy_q);
  a_r7_end_after_last: assert property (@(posedge clk) disable iff (rst)
    (busy_q && last_q && !go) |=> !busy_q);
  a_r6_page_no_last: assert property (@(posedge clk) disable iff (rst)
    (busy_q && page_q) |-> !last_q);
  a_r6_page_step: assert property (@(posedge clk) disable iff (rst)
    (busy_q && page_q && $past(busy_q) && !$past(go))
      |-> col_q == $past(col_q) + COL_W'(1));
  a_r4_upper_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !page_q && $past(busy_q) && !$past(go))
      |-> (col_q & ~mask_q) == ($past(col_q) & ~mask_q));
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             burst_go,
  input  logic [COL_W-1:0] go_col,
  input  logic [2:0]       go_len,
  input  logic             go_ilv,
  input  logic             burst_stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_busy,
  output logic             col_last
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] beat_inc;
  logic             ilv_q;
  logic [COL_W-1:0] nxt_col;

  bcg_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code  (go_len),
    .low_mask  (dec_mask),
    .page_mode (dec_page)
  );

  bcg_addr_calc #(.COL_W(COL_W)) u_calc (
    .base_col  (base_q),
    .low_mask  (mask_q),
    .beat_idx  (beat_inc),
    .xor_order (ilv_q),
    .beat_col  (nxt_col)
  );

  bcg_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .go       (burst_go),
    .go_col   (go_col),
    .go_ilv   (go_ilv),
    .go_mask  (dec_mask),
    .go_page  (dec_page),
    .stop     (burst_stop),
    .nxt_col  (nxt_col),
    .base_q   (base_q),
    .mask_q   (mask_q),
    .beat_inc (beat_inc),
    .ilv_q    (ilv_q),
    .col_q    (col_out),
    .busy_q   (col_busy),
    .last_q   (col_last)
  );

  a_r1_idle_no_last: assert property (@(posedge clk) disable iff (rst)
    !col_busy |-> !col_last);
endmodule

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;
  localparam int COL_W = 9;
  localparam int NCOL  = 1 << COL_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst;
  logic             burst_go;
  logic [COL_W-1:0] go_col;
  logic [2:0]       go_len;
  logic             go_ilv;
  logic             burst_stop;
  logic [COL_W-1:0] col_out;
  logic             col_busy;
  logic             col_last;

  burst_col_gen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst(rst), .burst_go(burst_go), .go_col(go_col),
    .go_len(go_len), .go_ilv(go_ilv), .burst_stop(burst_stop),
    .col_out(col_out), .col_busy(col_busy), .col_last(col_last)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // bench model state
  bit    m_busy = 0;
  int    m_base = 0;
  int    m_beat = 0;
  int    m_len  = 1;   // 0 means full page
  bit    m_il   = 0;
  string m_why  = "R1";

  function automatic int dec_len(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int mask;
    if (m_len == 0) return (m_base + m_beat) % NCOL;
    mask = m_len - 1;
    if (m_il) return (m_base & ~mask) | ((m_base ^ m_beat) & mask);
    return (m_base & ~mask) | ((m_base + m_beat) & mask);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // one clock: check outputs, drive inputs, advance the model
  task automatic cycle(bit st, int sc, int code, bit il, bit tm);
    string ctag;
    @(negedge clk);
    chk(m_why, col_busy, m_busy);
    if (m_busy) begin
      if (m_beat == 0)      ctag = "R2";
      else if (m_len == 0)  ctag = "R6";
      else if (m_il)        ctag = "R5";
      else                  ctag = "R4";
      chk(ctag, col_out, exp_col());
      chk(m_len == 0 ? "R6" : "R7", col_last,
          (m_len != 0 && m_beat == m_len - 1) ? 1 : 0);
    end else begin
      chk("R7", col_last, 0);
    end
    burst_go   = st;
    go_col     = COL_W'(sc);
    go_len     = 3'(code);
    go_ilv     = il;
    burst_stop = tm;
    if (st) begin
      m_why  = m_busy ? "R9" : "R2";
      m_busy = 1;
      m_base = sc;
      m_beat = 0;
      m_len  = dec_len(code);
      m_il   = il;
    end else if (tm) begin
      m_why  = "R8";
      m_busy = 0;
    end else if (m_busy) begin
      m_why = "R7";
      if (m_len != 0 && m_beat == m_len - 1) m_busy = 0;
      else m_beat++;
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cycle(0, 0, 0, 0, 0);
  endtask

  task automatic len_probe(int code, bit il);
    int n;
    n = 0;
    cycle(1, 37, code, il, 0);
    for (int k = 0; k < 20; k++) begin
      cycle(0, 0, 0, 0, 0);
      if (col_busy) n++;
      else break;
    end
    chk("R3", n, dec_len(code));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_sink;
    int pcount;
    seed_sink  = $urandom(32'd9137);
    rst        = 1'b1;
    burst_go   = 1'b0;
    go_col     = '0;
    go_len     = '0;
    go_ilv     = 1'b0;
    burst_stop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", col_busy, 0);
    chk("R1", col_last, 0);
    rst = 1'b0;
    idle(2);

    // R3 every code, both orderings for fixed lengths
    for (int c = 0; c < 7; c++) begin
      len_probe(c, 0);
      len_probe(c, 1);
    end

    // R5 interleave of 8 from an odd start
    cycle(1, 'h0FD, 3, 1, 0);
    idle(9);
    // R4 sequential of 8 from the same start
    cycle(1, 'h0FD, 3, 0, 0);
    idle(9);

    // R6 full page near the top, interleave ignored, runs past the wrap
    cycle(1, 505, 7, 1, 0);
    pcount = 0;
    for (int k = 0; k < 600; k++) begin
      cycle(0, 0, 0, 0, 0);
      if (col_busy) pcount++;
    end
    chk("R6", pcount, 600);
    cycle(0, 0, 0, 0, 1);  // R8 stop
    idle(3);
    chk("R8", col_busy, 0);

    // R8 stop while idle has no effect
    cycle(0, 0, 0, 0, 1);
    idle(2);
    chk("R8", col_busy, 0);

    // R9 restart on the last beat of a 4-beat burst
    cycle(1, 'h40, 2, 0, 0);
    idle(3);
    cycle(1, 'h1F2, 1, 1, 0);
    idle(3);
    // R9 start together with stop mid-burst
    cycle(1, 'h11, 3, 0, 0);
    idle(2);
    cycle(1, 'h1FF, 0, 0, 1);
    idle(3);
    // R8 stop in the middle of an 8-beat burst
    cycle(1, 'h80, 3, 1, 0);
    idle(3);
    cycle(0, 0, 0, 0, 1);
    idle(3);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      bit st;
      bit tm;
      st = ($urandom % 6) == 0;
      tm = ($urandom % 25) == 0;
      cycle(st, int'($urandom % NCOL), int'($urandom % 8), bit'($urandom % 2), tm);
    end
    cycle(0, 0, 0, 0, 1);
    idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule